// File: doc/BRIEF.md
# Edge-Counting I2C Target Shift Unit

This block is the bit-level engine of an I2C target. It watches the two open-drain bus lines through a synchroniser and finds START and STOP conditions. A 4-bit counter tallies every SCL transition. It shifts received bits in MSB first and shifts transmit bits out. At three defined points it holds SCL low until the host logic has serviced the bus: after a START, after the eighth data bit, and after the acknowledge bit. The host sees one status flag for each of these holds. It reads or prepares data, then pulses a single release input.

After a START, edge counting stays disarmed until both SCL and SDA are seen low. This places the first counted edge on the rising edge of data bit 0. The counter therefore overflows on the falling edge that ends the eighth bit. The byte stretch then always begins while SCL is already low, never in the middle of a bit. For the acknowledge bit the counter is preset so that it overflows after two edges. A cycle watchdog abandons the disarmed wait if the lines never both go low.

Address matching and register storage belong to the host logic, not to this block.

Top module: `i2c_edge_shifter`

## Requirements
- R1: A START (synchronised SDA falls while synchronised SCL stays high) moves the block into a disarmed wait. No stretch is applied while SCL is still high. Once both lines are low, `scl_low_o` and `start_seen_o` are asserted until `release_i` is pulsed.
- R2: While disarmed after a START, no SCL edge is counted. The first counted edge is the first SCL rising edge after the post-START stretch is released.
- R3: The 16th counted SCL edge of a byte (the falling edge of the eighth bit) asserts `scl_low_o` and `byte_rdy_o`. Both stay high until `release_i`. The block never starts a stretch while SCL is high.
- R4: Received bits are sampled on SCL rising edges, MSB first. `rx_byte_o` holds the complete byte while `byte_rdy_o` is high.
- R5: Releasing the byte stretch starts a 2-edge acknowledge phase. In receive mode (`tx_mode_i`=0), SDA is pulled low during this phase when `ack_i`=1 and left released when `ack_i`=0. After the acknowledge falling edge, `scl_low_o` and `ack_done_o` are held until `release_i`.
- R6: In transmit mode (`tx_mode_i`=1), `tx_byte_i` is loaded when the post-START or post-acknowledge stretch is released. It is driven MSB first, and `sda_low_o` is 1 when the current bit is 0. The output changes only while SCL is low.
- R7: In transmit mode, SDA is released during the acknowledge phase. The level sampled on the acknowledge rising edge appears on `ack_bit_o` (0 = ACK, 1 = NACK).
- R8: A STOP (SDA rises while SCL is high) returns the block to idle from any state and releases both lines. After reset both pull-low enables and all status flags are 0.
- R9: If the lines are not both low within `WAIT_LIMIT` cycles after a START, the block returns to idle. A later SCL fall then causes no stretch.
- R10: A repeated START in the middle of a byte discards the partial byte and re-arms the block. The next full byte is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low |
| tx_mode_i | input | 1 | 1 = block sends data, 0 = block receives |
| tx_byte_i | input | BYTE_W | Byte to send, loaded at stretch release |
| ack_i | input | 1 | Receive mode: 1 = acknowledge the byte |
| release_i | input | 1 | One-cycle pulse ending the current stretch |
| start_seen_o | output | 1 | Stretch after START is active |
| byte_rdy_o | output | 1 | Stretch after eighth data bit is active |
| ack_done_o | output | 1 | Stretch after acknowledge bit is active |
| rx_byte_o | output | BYTE_W | Received byte |
| ack_bit_o | output | 1 | Acknowledge level sampled in transmit mode |

## Verification
The bench targets the edge that arms the counter. A design that counts from the START itself overflows on a rising edge and stretches mid-bit, and the per-clock model flags the early `byte_rdy_o`. It sends a NACK byte and transmits data with zero and one bits mixed, so an inverted acknowledge drive or a transmit shift taken on the wrong SCL edge shows up as a wrong bus level sampled by the bench controller. It breaks off a byte with a repeated START and holds the bus so that the disarmed wait times out. A design that keeps stale counts, or that never leaves the wait, then stretches where the model expects a free bus.

// File: rtl/i2c_es_pkg.sv
package i2c_es_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ARM        = 3'd1,
    ST_HOLD_START = 3'd2,
    ST_DATA       = 3'd3,
    ST_HOLD_BYTE  = 3'd4,
    ST_ACK        = 3'd5,
    ST_HOLD_ACK   = 3'd6
  } es_state_t;

  // counter value that overflows after 'edges' further edges
  function automatic logic [7:0] edge_preload(input int unsigned cnt_w,
                                              input int unsigned edges);
    int unsigned span;
    span = (1 << cnt_w) - edges;
    return 8'(span);
  endfunction

  // counter at its last value before wrap
  function automatic logic at_wrap(input logic [7:0] cnt, input int unsigned cnt_w);
    return cnt == 8'((1 << cnt_w) - 1);
  endfunction

  function automatic logic holds_clock(input es_state_t st);
    return (st == ST_HOLD_START) || (st == ST_HOLD_BYTE) || (st == ST_HOLD_ACK);
  endfunction

endpackage

// File: rtl/i2c_es_sync.sv
module i2c_es_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_es_events.sv
module i2c_es_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  logic scl_steady_hi;
  assign scl_steady_hi = scl_p & scl_s;
  assign scl_rise = ~scl_p & scl_s;
  assign scl_fall = scl_p & ~scl_s;
  assign start_ev = scl_steady_hi & sda_p & ~sda_s;
  assign stop_ev  = scl_steady_hi & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_es_ctrl.sv
module i2c_es_ctrl
  import i2c_es_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int BYTE_W     = 8,
  parameter int ACK_EDGES  = 2,
  parameter int WAIT_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              release_i,
  output es_state_t         state_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              tx_bit_o,
  output logic              ack_bit_o
);

  localparam int WD_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] ACK_LOAD = CNT_W'(edge_preload(CNT_W, ACK_EDGES));

  es_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [WD_W-1:0]   wd;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              ack_q;

  logic scl_edge, both_low, wd_expired, cnt_last;
  assign scl_edge   = scl_rise | scl_fall;
  assign both_low   = ~scl_s & ~sda_s;
  assign wd_expired = (wd == WD_W'(WAIT_LIMIT - 1));
  assign cnt_last   = at_wrap(8'(cnt), CNT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wd    <= '0;
      rx_sh <= '0;
      tx_sh <= '1;
      ack_q <= 1'b1;
    end else if (start_ev) begin
      state <= ST_ARM;
      wd    <= '0;
      cnt   <= '0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tx_sh <= '1;
    end else begin
      case (state)
        ST_ARM: begin
          if (both_low)        state <= ST_HOLD_START;
          else if (wd_expired) state <= ST_IDLE;
          else                 wd    <= wd + 1'b1;
        end
        ST_HOLD_START: begin
          if (release_i) begin
            state <= ST_DATA;
            cnt   <= '0;
            tx_sh <= tx_byte_i;
          end
        end
        ST_DATA: begin
          if (scl_edge) begin
            cnt <= cnt + 1'b1;
            if (cnt_last) state <= ST_HOLD_BYTE;
          end
          if (scl_rise) rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
          if (scl_fall) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
        end
        ST_HOLD_BYTE: begin
          if (release_i) begin
            state <= ST_ACK;
            cnt   <= ACK_LOAD;
          end
        end
        ST_ACK: begin
          if (scl_edge) begin
            cnt <= cnt + 1'b1;
            if (cnt_last) state <= ST_HOLD_ACK;
          end
          if (scl_rise) ack_q <= sda_s;
        end
        ST_HOLD_ACK: begin
          if (release_i) begin
            state <= ST_DATA;
            cnt   <= '0;
            tx_sh <= tx_byte_i;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state;
  assign rx_byte_o = rx_sh;
  assign tx_bit_o  = tx_sh[BYTE_W-1];
  assign ack_bit_o = ack_q;

endmodule

// File: rtl/i2c_edge_shifter.sv
module i2c_edge_shifter
  import i2c_es_pkg::*;
#(
  parameter int EDGE_CNT_W = 4,
  parameter int ACK_EDGES  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_LIMIT = 1000,
  localparam int BYTE_W    = 1 << (EDGE_CNT_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              tx_mode_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              ack_i,
  input  logic              release_i,
  output logic              start_seen_o,
  output logic              byte_rdy_o,
  output logic              ack_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              ack_bit_o
);

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  es_state_t  state;
  logic       tx_bit;

  i2c_es_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({sda_i, scl_i}), .sync_o(line_s)
  );
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2c_es_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_es_ctrl #(
    .CNT_W(EDGE_CNT_W), .BYTE_W(BYTE_W),
    .ACK_EDGES(ACK_EDGES), .WAIT_LIMIT(WAIT_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_byte_i(tx_byte_i), .release_i(release_i),
    .state_o(state), .rx_byte_o(rx_byte_o),
    .tx_bit_o(tx_bit), .ack_bit_o(ack_bit_o)
  );

  assign scl_low_o    = holds_clock(state);
  assign sda_low_o    = ((state == ST_DATA) & tx_mode_i & ~tx_bit) |
                        ((state == ST_ACK) & ~tx_mode_i & ack_i);
  assign start_seen_o = (state == ST_HOLD_START);
  assign byte_rdy_o   = (state == ST_HOLD_BYTE);
  assign ack_done_o   = (state == ST_HOLD_ACK);

endmodule

// File: rtl/i2c_es_checker.sv
module i2c_es_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic start_seen_o,
  input logic byte_rdy_o,
  input logic ack_done_o
);

  AST_START_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !scl_low_o); // R1

  AST_ARM_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_seen_o) |-> !$past(scl_s)); // R2

  AST_BYTE_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_rdy_o) |-> !$past(scl_s)); // R3

  AST_ACK_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_done_o) |-> !$past(scl_s)); // R5

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_low_o) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_s)); // R6

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!scl_low_o && !sda_low_o)); // R8

endmodule

bind i2c_edge_shifter i2c_es_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
  .start_ev(start_ev), .stop_ev(stop_ev),
  .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
  .start_seen_o(start_seen_o), .byte_rdy_o(byte_rdy_o), .ack_done_o(ack_done_o)
);

// File: tb/sim_i2c_edge_shifter.sv
`timescale 1ns/1ps
module sim_i2c_edge_shifter;

  localparam int WAIT = 64;
  localparam int T    = 8;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic tx_mode = 1'b0, ack_in = 1'b1, rel = 1'b0;
  logic [7:0] tx_byte = 8'hFF;
  logic scl_low, sda_low, start_seen, byte_rdy, ack_done, ack_bit;
  logic [7:0] rx_byte;
  logic host_on = 1'b1;

  wire bus_scl = m_scl & ~scl_low;
  wire bus_sda = m_sda & ~sda_low;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  i2c_edge_shifter #(.WAIT_LIMIT(WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_low_o(scl_low), .sda_low_o(sda_low),
    .tx_mode_i(tx_mode), .tx_byte_i(tx_byte), .ack_i(ack_in), .release_i(rel),
    .start_seen_o(start_seen), .byte_rdy_o(byte_rdy), .ack_done_o(ack_done),
    .rx_byte_o(rx_byte), .ack_bit_o(ack_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 idle,1 waiting,2 start hold,3 data,4 byte hold,5 ack,6 ack hold
  int ph = 0, left = 0, waited = 0;
  int hc[3] = '{1, 1, 1};
  int hd[3] = '{1, 1, 1};
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0;
      hc = '{1, 1, 1};
      hd = '{1, 1, 1};
    end else begin
      int cn, cp, dn, dp;
      bit st, sp, ed;
      cn = hc[1]; cp = hc[2]; dn = hd[1]; dp = hd[2];
      st = (cp == 1) && (cn == 1) && (dp == 1) && (dn == 0);
      sp = (cp == 1) && (cn == 1) && (dp == 0) && (dn == 1);
      ed = (cn != cp);
      if (st) begin ph = 1; waited = 0; end
      else if (sp) ph = 0;
      else begin
        case (ph)
          1: if (cn == 0 && dn == 0) ph = 2;
             else begin waited++; if (waited >= WAIT) ph = 0; end
          2: if (rel) begin ph = 3; left = 16; end
          3: if (ed) begin left--; if (left == 0) ph = 4; end
          4: if (rel) begin ph = 5; left = 2; end
          5: if (ed) begin left--; if (left == 0) ph = 6; end
          6: if (rel) begin ph = 3; left = 16; end
          default: ;
        endcase
      end
      hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = int'(bus_scl);
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = int'(bus_sda);
    end
  end

  // per-clock comparison of hold flags (R1 R2 R3 R5 R8 R9 R10)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int got, exp;
      got = {scl_low, start_seen, byte_rdy, ack_done};
      exp = {(ph == 2 || ph == 4 || ph == 6), ph == 2, ph == 4, ph == 6};
      chk(got == exp, "R3 model stretch flags", got, exp);
    end
  end

  // host: releases each stretch HOLD cycles after it starts
  int hold_cnt = 0;
  initial forever begin
    @(negedge clk);
    rel = 1'b0;
    if (host_on && scl_low) begin
      hold_cnt++;
      if (hold_cnt == HOLD) begin rel = 1'b1; hold_cnt = 0; end
    end else hold_cnt = 0;
  end

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask
  task automatic scl_up(); m_scl = 1'b1; do @(negedge clk); while (!bus_scl); endtask

  task automatic start_cond();
    m_sda = 1'b1; wait_n(T); scl_up(); wait_n(T);
    m_sda = 1'b0; wait_n(T);
    chk(scl_low == 1'b0, "R1 no stretch while SCL high", scl_low, 0);
    m_scl = 1'b0; wait_n(T);
    chk(start_seen == 1'b1, "R1 start hold", start_seen, 1);
  endtask

  task automatic stop_cond();
    m_sda = 1'b0; wait_n(T); scl_up(); wait_n(T);
    m_sda = 1'b1; wait_n(T);
    chk({scl_low, sda_low} == 2'b00, "R8 lines released after stop", {scl_low, sda_low}, 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_sda);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_n(T); scl_up(); wait_n(T); m_scl = 1'b0;
    end
    do @(negedge clk); while (!byte_rdy);
    chk(rx_byte == b, "R4 received byte", rx_byte, b);
    m_sda = 1'b1;
    scl_up(); wait_n(T);
    chk(bus_sda == exp_sda, "R5 ack level", bus_sda, exp_sda);
    m_scl = 1'b0;
    do @(negedge clk); while (!ack_done);
  endtask

  task automatic read_byte(input logic [7:0] exp, input logic nack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_up(); wait_n(T);
      chk(bus_sda == exp[i], "R6 transmit bit", bus_sda, exp[i]);
      m_scl = 1'b0; wait_n(T);
    end
    m_sda = nack;
    scl_up(); wait_n(T); m_scl = 1'b0;
    do @(negedge clk); while (!ack_done);
    chk(ack_bit == nack, "R7 captured ack", ack_bit, nack);
    m_sda = 1'b1;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    summary();
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk({scl_low, sda_low, start_seen, byte_rdy, ack_done} == 5'b0, "R8 reset state",
        {scl_low, sda_low, start_seen, byte_rdy, ack_done}, 0);

    // receive with ACK, two bytes (R1 R2 R3 R4 R5)
    ack_in = 1'b1;
    start_cond();
    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b0);
    stop_cond();

    // receive with NACK (R5)
    ack_in = 1'b0;
    start_cond();
    send_byte(8'hFF, 1'b1);
    stop_cond();
    ack_in = 1'b1;

    // transmit two bytes (R6 R7)
    tx_mode = 1'b1; tx_byte = 8'h96;
    start_cond();
    read_byte(8'h96, 1'b0);
    tx_byte = 8'h4B;
    read_byte(8'h4B, 1'b1);
    tx_mode = 1'b0;
    stop_cond();

    // repeated START inside a byte (R10)
    start_cond();
    for (int k = 0; k < 3; k++) begin
      m_sda = 1'b0; wait_n(T); scl_up(); wait_n(T); m_scl = 1'b0;
    end
    start_cond();
    send_byte(8'h5A, 1'b0);
    chk(rx_byte == 8'h5A, "R10 byte after repeated start", rx_byte, 8'h5A);
    stop_cond();

    // wait timeout after START (R9)
    m_sda = 1'b0;
    wait_n(WAIT + 20);
    chk(scl_low == 1'b0, "R9 no hold during timeout", scl_low, 0);
    m_scl = 1'b0;
    wait_n(20);
    chk(scl_low == 1'b0, "R9 no stretch after abort", scl_low, 0);
    m_scl = 1'b1; wait_n(T);
    m_sda = 1'b1; wait_n(T);

    // normal traffic after abort (R9)
    start_cond();
    send_byte(8'hC3, 1'b0);
    chk(rx_byte == 8'hC3, "R9 recovery byte", rx_byte, 8'hC3);
    stop_cond();

    wait_n(10);
    summary();
  end

endmodule